// File: doc/BRIEF.md
# System Power and Clock Control Register

This block is a single byte-wide special-function register, together with the small amount of logic behind it, that a compact microcontroller subsystem uses to manage power and timing. Through one bus address, software can ask for a system shutdown, read whether the last power-up came from a battery being inserted, reset a free-running real-time tick counter, freeze the GPIO output bank, and choose the system clock rate as the fast reference clock divided by a power of two.

The divided clock is not a second clock. It is delivered as a one-cycle clock-enable pulse taken from a free-running prescaler. A new divide setting is applied only when the prescaler wraps, so no enable period is ever cut short. Once shutdown has been requested, the block waits for a falling edge on any GPIO input. It answers that edge with a reset pulse several cycles long, which the surrounding power-on-reset logic uses. When the port-hold bit is set ahead of shutdown, button edges that arrive during the shutdown sequence are remembered rather than lost. They take effect only after shutdown has been entered.

The analog power switch, the oscillator and the power-on-reset circuit are outside this block. Its only contact with them is through the shutdown request and wake-up reset signals.

Top module: `sysPowerClkCtl`

## Requirements
- R1: The register is decoded at bus address 0xBE. After reset it reads back as 0x00. Reads at any other address return 0x00, and writes to any other address change nothing.
- R2: A write at 0xBE with bit 7 set, made while the block is running, raises `shutdownReq` for exactly one cycle: the cycle after the write edge. Bit 7 always reads back as 0.
- R3: Bit 6 always reads 0, whatever was written to it. Bit 4 also always reads 0.
- R4: Bit 5 is a read-only power-up flag. It becomes 1 one cycle after `battPowerUp` is sampled high and then stays at 1 until reset. Writes to it have no effect.
- R5: A write at 0xBE with bit 4 set clears `tickCount` and its prescaler on that same edge. A write with bit 4 clear leaves both untouched.
- R6: `tickCount` advances by one every TICK_DIV reference cycles and wraps at its full width.
- R7: Bit 3 is port hold. While it is 1, `gpioOut` keeps the value that `gpioOutReq` had at the edge where the hold was written. While it is 0, `gpioOut` follows `gpioOutReq`.
- R8: While shut down, a falling edge on any `gpioIn` bit (1 at one clock edge, 0 at the next) raises `wakeReset` on the following cycle. `wakeReset` stays high for WAKE_PULSE cycles, after which the block is running again. A falling edge while running with hold clear causes no wake-up.
- R9: A falling edge seen while hold is 1 and the block is running is remembered. The wake-up then starts one cycle after shutdown has been entered. Clearing hold before shutdown discards the remembered edge.
- R10: Bits 2:0 hold the divide exponent N. Once applied, N makes `clkEn` pulse once every 2^N reference cycles; N = 0 gives a pulse on every cycle.
- R11: A new N takes effect only when the 7-bit prescaler passes from all-ones to zero. Until then the previous N continues to set the pulse spacing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast reference clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sfrAddr | input | ADDR_W | Register bus address |
| sfrWrData | input | 8 | Register bus write data |
| sfrWrEn | input | 1 | Write strobe, sampled on the clock edge |
| sfrRdData | output | 8 | Read data for the current address |
| gpioIn | input | GPIO_W | GPIO input levels, already synchronous |
| gpioOutReq | input | GPIO_W | GPIO output values requested by the port logic |
| gpioOut | output | GPIO_W | GPIO output values after port hold is applied |
| battPowerUp | input | 1 | High when the power-up was caused by battery insertion |
| shutdownReq | output | 1 | One-cycle request to the power switch |
| wakeReset | output | 1 | Wake-up reset pulse to the power-on-reset logic |
| clkEn | output | 1 | Divided system clock enable |
| tickCount | output | TICK_W | Real-time tick count |

## Verification
The bench builds the block with GPIO_W = 4, TICK_W = 4, TICK_DIV = 123 and WAKE_PULSE = 4. A 4-bit tick counter wraps after about two thousand cycles, so both the roll-over and the exact 123-cycle tick spacing can be observed. All eight divide settings, including the 128-cycle one, fit into runs of a few hundred cycles, and each setting change is compared cycle by cycle against the prescaler wrap. The four-bit GPIO bank is enough to show that an edge on any single bit wakes the block, and that a remembered edge survives until shutdown or is discarded when hold is cleared.

// File: rtl/sysgen_pkg.sv
`timescale 1ns/1ps
package sysgen_pkg;
  localparam int SFR_DW = 8;
  localparam int DIV_W  = 3;

  // Field positions within the register byte
  localparam int FLD_SHUT  = 7;
  localparam int FLD_RSV   = 6;
  localparam int FLD_FIRST = 5;
  localparam int FLD_TCLR  = 4;
  localparam int FLD_HOLD  = 3;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_SHUT = 2'd1,
    ST_WAKE = 2'd2
  } pwrState_t;

  typedef struct packed {
    logic cfgWr;    // load hold and divider fields
    logic tickClr;  // clear real-time counter
  } ctlStrobe_t;
endpackage

// File: rtl/sysgenClkDiv.sv
`timescale 1ns/1ps
module sysgenClkDiv #(
  parameter int DIV_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] divSel,
  output logic             clkEn
);
  localparam int PRE_W = (1 << DIV_W) - 1;

  logic [PRE_W-1:0] preCnt;
  logic [DIV_W-1:0] activeDiv;
  logic [PRE_W-1:0] mask;
  logic             wrapNow;

  assign wrapNow = &preCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt    <= '0;
      activeDiv <= '0;
    end else begin
      preCnt <= preCnt + 1'b1;
      if (wrapNow) activeDiv <= divSel;
    end
  end

  // Low bits of the prescaler that must all be set for a pulse
  for (genvar i = 0; i < PRE_W; i++) begin : gMask
    assign mask[i] = int'(activeDiv) > i;
  end

  assign clkEn = (preCnt & mask) == mask;
endmodule

// File: rtl/sysgenRtcTick.sv
`timescale 1ns/1ps
module sysgenRtcTick #(
  parameter int TICK_DIV = 123,
  parameter int TICK_W   = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickClr,
  output logic [TICK_W-1:0] tickCount
);
  localparam int PRE_W = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);

  logic [PRE_W-1:0] preQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preQ      <= '0;
      tickCount <= '0;
    end else if (tickClr) begin
      preQ      <= '0;
      tickCount <= '0;
    end else if (preQ == PRE_LAST) begin
      preQ      <= '0;
      tickCount <= tickCount + 1'b1;
    end else begin
      preQ <= preQ + 1'b1;
    end
  end
endmodule

// File: rtl/sysgenDp.sv
`timescale 1ns/1ps
module sysgenDp
  import sysgen_pkg::*;
#(
  parameter int                ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] SFR_ADDR = 8'hBE,
  parameter int                GPIO_W   = 8,
  parameter int                TICK_DIV = 123,
  parameter int                TICK_W   = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  logic              holdIn,
  input  logic [DIV_W-1:0]  divIn,
  input  logic [ADDR_W-1:0] sfrAddr,
  input  logic              battPowerUp,
  input  logic [GPIO_W-1:0] gpioOutReq,
  output logic [GPIO_W-1:0] gpioOut,
  output logic [SFR_DW-1:0] sfrRdData,
  output logic              portHold,
  output logic              clkEn,
  output logic [TICK_W-1:0] tickCount
);
  logic              holdQ;
  logic [DIV_W-1:0]  divQ;
  logic              firstQ;
  logic [GPIO_W-1:0] frozenQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdQ   <= 1'b0;
      divQ    <= '0;
      firstQ  <= 1'b0;
      frozenQ <= '0;
    end else begin
      if (strobe.cfgWr) begin
        holdQ <= holdIn;
        divQ  <= divIn;
      end
      if (battPowerUp) firstQ <= 1'b1;
      if (!holdQ) frozenQ <= gpioOutReq;
    end
  end

  assign gpioOut  = holdQ ? frozenQ : gpioOutReq;
  assign portHold = holdQ;

  always_comb begin
    sfrRdData = '0;
    if (sfrAddr == SFR_ADDR) begin
      sfrRdData[FLD_FIRST]   = firstQ;
      sfrRdData[FLD_HOLD]    = holdQ;
      sfrRdData[DIV_W-1:0]   = divQ;
    end
  end

  sysgenClkDiv #(
    .DIV_W(DIV_W)
  ) uDiv (
    .clk   (clk),
    .rstN  (rstN),
    .divSel(divQ),
    .clkEn (clkEn)
  );

  sysgenRtcTick #(
    .TICK_DIV(TICK_DIV),
    .TICK_W  (TICK_W)
  ) uTick (
    .clk      (clk),
    .rstN     (rstN),
    .tickClr  (strobe.tickClr),
    .tickCount(tickCount)
  );
endmodule

// File: rtl/sysgenCtl.sv
`timescale 1ns/1ps
module sysgenCtl
  import sysgen_pkg::*;
#(
  parameter int                ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] SFR_ADDR   = 8'hBE,
  parameter int                GPIO_W     = 8,
  parameter int                WAKE_PULSE = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] sfrAddr,
  input  logic              sfrWrEn,
  input  logic              shutBit,
  input  logic              clrBit,
  input  logic [GPIO_W-1:0] gpioIn,
  input  logic              portHold,
  output ctlStrobe_t        strobe,
  output logic              shutdownReq,
  output logic              wakeReset
);
  localparam int WAKE_W = (WAKE_PULSE > 2) ? $clog2(WAKE_PULSE) : 1;
  localparam logic [WAKE_W-1:0] WAKE_LOAD = WAKE_W'(WAKE_PULSE - 1);

  pwrState_t         stateQ;
  logic [WAKE_W-1:0] wakeCnt;
  logic [GPIO_W-1:0] gpioPrev;
  logic              pendQ;
  logic              shutQ;
  logic              wrHit;
  logic              anyFall;
  logic              enterShut;
  logic              enterWake;

  assign wrHit     = sfrWrEn && (sfrAddr == SFR_ADDR);
  assign anyFall   = |(gpioPrev & ~gpioIn);
  assign enterShut = (stateQ == ST_RUN) && wrHit && shutBit;
  assign enterWake = (stateQ == ST_SHUT) && (anyFall || pendQ);

  assign strobe.cfgWr   = wrHit;
  assign strobe.tickClr = wrHit && clrBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ   <= ST_RUN;
      wakeCnt  <= '0;
      gpioPrev <= '0;
      pendQ    <= 1'b0;
      shutQ    <= 1'b0;
    end else begin
      gpioPrev <= gpioIn;
      shutQ    <= enterShut;

      if (enterWake)                            pendQ <= 1'b0;
      else if (!portHold)                       pendQ <= 1'b0;
      else if ((stateQ == ST_RUN) && anyFall)   pendQ <= 1'b1;

      unique case (stateQ)
        ST_RUN: begin
          if (enterShut) stateQ <= ST_SHUT;
        end
        ST_SHUT: begin
          if (enterWake) begin
            stateQ  <= ST_WAKE;
            wakeCnt <= WAKE_LOAD;
          end
        end
        ST_WAKE: begin
          if (wakeCnt == '0) stateQ <= ST_RUN;
          else               wakeCnt <= wakeCnt - 1'b1;
        end
        default: stateQ <= ST_RUN;
      endcase
    end
  end

  assign shutdownReq = shutQ;
  assign wakeReset   = (stateQ == ST_WAKE);
endmodule

// File: rtl/sysPowerClkCtl.sv
`timescale 1ns/1ps
module sysPowerClkCtl
  import sysgen_pkg::*;
#(
  parameter int                ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] SFR_ADDR   = 8'hBE,
  parameter int                GPIO_W     = 8,
  parameter int                TICK_DIV   = 123,
  parameter int                TICK_W     = 16,
  parameter int                WAKE_PULSE = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] sfrAddr,
  input  logic [7:0]        sfrWrData,
  input  logic              sfrWrEn,
  output logic [7:0]        sfrRdData,
  input  logic [GPIO_W-1:0] gpioIn,
  input  logic [GPIO_W-1:0] gpioOutReq,
  output logic [GPIO_W-1:0] gpioOut,
  input  logic              battPowerUp,
  output logic              shutdownReq,
  output logic              wakeReset,
  output logic              clkEn,
  output logic [TICK_W-1:0] tickCount
);
  ctlStrobe_t strobe;
  logic       portHold;

  sysgenCtl #(
    .ADDR_W    (ADDR_W),
    .SFR_ADDR  (SFR_ADDR),
    .GPIO_W    (GPIO_W),
    .WAKE_PULSE(WAKE_PULSE)
  ) uCtl (
    .clk        (clk),
    .rstN       (rstN),
    .sfrAddr    (sfrAddr),
    .sfrWrEn    (sfrWrEn),
    .shutBit    (sfrWrData[FLD_SHUT]),
    .clrBit     (sfrWrData[FLD_TCLR]),
    .gpioIn     (gpioIn),
    .portHold   (portHold),
    .strobe     (strobe),
    .shutdownReq(shutdownReq),
    .wakeReset  (wakeReset)
  );

  sysgenDp #(
    .ADDR_W  (ADDR_W),
    .SFR_ADDR(SFR_ADDR),
    .GPIO_W  (GPIO_W),
    .TICK_DIV(TICK_DIV),
    .TICK_W  (TICK_W)
  ) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .holdIn     (sfrWrData[FLD_HOLD]),
    .divIn      (sfrWrData[DIV_W-1:0]),
    .sfrAddr    (sfrAddr),
    .battPowerUp(battPowerUp),
    .gpioOutReq (gpioOutReq),
    .gpioOut    (gpioOut),
    .sfrRdData  (sfrRdData),
    .portHold   (portHold),
    .clkEn      (clkEn),
    .tickCount  (tickCount)
  );
endmodule

// File: rtl/sysPowerClkCtl_chk.sv
`timescale 1ns/1ps
module sysPowerClkCtl_chk #(
  parameter int                ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] SFR_ADDR = 8'hBE,
  parameter int                GPIO_W   = 8,
  parameter int                TICK_W   = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] sfrAddr,
  input logic [7:0]        sfrWrData,
  input logic              sfrWrEn,
  input logic [7:0]        sfrRdData,
  input logic [GPIO_W-1:0] gpioOut,
  input logic              battPowerUp,
  input logic              shutdownReq,
  input logic              wakeReset,
  input logic [TICK_W-1:0] tickCount
);
  logic wrHit;
  logic holdSeen;
  logic shutSeen;
  logic battSeen;

  assign wrHit = sfrWrEn && (sfrAddr == SFR_ADDR);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdSeen <= 1'b0;
      shutSeen <= 1'b0;
      battSeen <= 1'b0;
    end else begin
      if (wrHit) holdSeen <= sfrWrData[3];
      if (shutdownReq) shutSeen <= 1'b1;
      else if (wakeReset) shutSeen <= 1'b0;
      if (battPowerUp) battSeen <= 1'b1;
    end
  end

  AST_SHUT_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    shutdownReq |=> !shutdownReq); // R2

  AST_SHUT_CAUSED: assert property (@(posedge clk) disable iff (!rstN)
    $rose(shutdownReq) |-> $past(wrHit && sfrWrData[7])); // R2

  AST_RSV_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (wrHit && sfrWrData[6]) |=> ((sfrAddr != SFR_ADDR) || !sfrRdData[6])); // R3

  AST_FIRST_RO: assert property (@(posedge clk) disable iff (!rstN)
    (wrHit && sfrWrData[5] && !battSeen && !battPowerUp) |=>
      ((sfrAddr != SFR_ADDR) || !sfrRdData[5])); // R4

  AST_TICK_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    (wrHit && sfrWrData[4]) |=> (tickCount == '0)); // R5

  AST_TICK_STEP: assert property (@(posedge clk) disable iff (!rstN)
    !(wrHit && sfrWrData[4]) |=>
      ((tickCount == $past(tickCount)) ||
       (tickCount == TICK_W'($past(tickCount) + 1'b1)))); // R6

  AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (holdSeen && $past(holdSeen)) |-> $stable(gpioOut)); // R7

  AST_WAKE_AFTER_SHUT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wakeReset) |-> shutSeen); // R8
endmodule

bind sysPowerClkCtl sysPowerClkCtl_chk #(
  .ADDR_W  (ADDR_W),
  .SFR_ADDR(SFR_ADDR),
  .GPIO_W  (GPIO_W),
  .TICK_W  (TICK_W)
) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .sfrAddr    (sfrAddr),
  .sfrWrData  (sfrWrData),
  .sfrWrEn    (sfrWrEn),
  .sfrRdData  (sfrRdData),
  .gpioOut    (gpioOut),
  .battPowerUp(battPowerUp),
  .shutdownReq(shutdownReq),
  .wakeReset  (wakeReset),
  .tickCount  (tickCount)
);

// File: tb/tb_sysPowerClkCtl.sv
`timescale 1ns/1ps
module tb_sysPowerClkCtl;
  localparam int GPIO_W = 4;
  localparam int TICK_W = 4;
  localparam int TICK_DIV = 123;
  localparam int WAKE_PULSE = 4;
  localparam logic [7:0] REG_A = 8'hBE;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [7:0]        sfrAddr = REG_A;
  logic [7:0]        sfrWrData = 8'h00;
  logic              sfrWrEn = 1'b0;
  logic [7:0]        sfrRdData;
  logic [GPIO_W-1:0] gpioIn = '1;
  logic [GPIO_W-1:0] gpioOutReq = '0;
  logic [GPIO_W-1:0] gpioOut;
  logic              battPowerUp = 1'b0;
  logic              shutdownReq;
  logic              wakeReset;
  logic              clkEn;
  logic [TICK_W-1:0] tickCount;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  sysPowerClkCtl #(
    .GPIO_W(GPIO_W), .TICK_DIV(TICK_DIV), .TICK_W(TICK_W), .WAKE_PULSE(WAKE_PULSE)
  ) dut (
    .clk(clk), .rstN(rstN), .sfrAddr(sfrAddr), .sfrWrData(sfrWrData),
    .sfrWrEn(sfrWrEn), .sfrRdData(sfrRdData), .gpioIn(gpioIn),
    .gpioOutReq(gpioOutReq), .gpioOut(gpioOut), .battPowerUp(battPowerUp),
    .shutdownReq(shutdownReq), .wakeReset(wakeReset), .clkEn(clkEn),
    .tickCount(tickCount)
  );

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int mState, mWake, mPre, mAct, mTickPre, mTick;
  bit mShut, mPend, mHold, mFirst;
  int mDiv, mFrozen, mPrev;

  always @(posedge clk) begin
    if (!rstN) begin
      mState = 0; mWake = 0; mPre = 0; mAct = 0; mTickPre = 0; mTick = 0;
      mShut = 0; mPend = 0; mHold = 0; mFirst = 0; mDiv = 0; mFrozen = 0; mPrev = 0;
    end else begin
      bit wr, fall, goShut, goWake, nPend;
      wr     = sfrWrEn && (sfrAddr == REG_A);
      fall   = (mPrev & ~int'(gpioIn)) != 0;
      goShut = (mState == 0) && wr && sfrWrData[7];
      goWake = (mState == 1) && (fall || mPend);
      if (goWake) nPend = 0;
      else if (!mHold) nPend = 0;
      else if (mState == 0 && fall) nPend = 1;
      else nPend = mPend;
      mPend = nPend;
      mShut = goShut;
      if (mState == 0 && goShut) mState = 1;
      else if (goWake) begin mState = 2; mWake = WAKE_PULSE - 1; end
      else if (mState == 2) begin
        if (mWake == 0) mState = 0; else mWake--;
      end
      mPrev = int'(gpioIn);
      if (!mHold) mFrozen = int'(gpioOutReq);
      if (mPre == 127) mAct = mDiv;
      mPre = (mPre + 1) % 128;
      if (wr && sfrWrData[4]) begin mTickPre = 0; mTick = 0; end
      else if (mTickPre == TICK_DIV - 1) begin mTickPre = 0; mTick = (mTick + 1) % (1 << TICK_W); end
      else mTickPre++;
      if (battPowerUp) mFirst = 1;
      if (wr) begin mHold = sfrWrData[3]; mDiv = int'(sfrWrData[2:0]); end
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rstN && !finished) begin
      int mask, expRd;
      mask  = (1 << mAct) - 1;
      expRd = (sfrAddr == REG_A) ? ((int'(mFirst) << 5) | (int'(mHold) << 3) | mDiv) : 0;
      check("R2 shutdownReq", int'(shutdownReq), int'(mShut));
      check("R8 wakeReset", int'(wakeReset), int'(mState == 2));
      check("R7 gpioOut", int'(gpioOut), mHold ? mFrozen : int'(gpioOutReq));
      check("R6 tickCount", int'(tickCount), mTick);
      check("R10 clkEn", int'(clkEn), int'((mPre & mask) == mask));
      check("R1 sfrRdData", int'(sfrRdData), expRd);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic sfrWrite(input logic [7:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    sfrAddr = a; sfrWrData = d; sfrWrEn = 1'b1;
    @(posedge clk); #1;
    sfrWrEn = 1'b0; sfrAddr = REG_A;
  endtask

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic finishRun;
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    int n;
    cycles(3);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 reset readback", int'(sfrRdData), 0);
    check("R2 reset shutdownReq", int'(shutdownReq), 0);

    // R1: other address is ignored
    sfrWrite(8'hBF, 8'h0B);
    @(negedge clk);
    check("R1 foreign write ignored", int'(sfrRdData), 0);
    #1 sfrAddr = 8'hBF;
    #0.5 check("R1 foreign read zero", int'(sfrRdData), 0);
    cycles(1); sfrAddr = REG_A;

    // R4: first-power flag
    @(posedge clk); #1 battPowerUp = 1'b1;
    @(posedge clk); #1 battPowerUp = 1'b0;
    sfrWrite(REG_A, 8'h00);
    @(negedge clk);
    check("R4 first-power sticky", int'(sfrRdData), 8'h20);

    // R3: reserved and strobe bits read zero
    sfrWrite(REG_A, 8'h57);
    @(negedge clk);
    check("R3 reserved and clear bits read zero", int'(sfrRdData), 8'h27);

    // R10: every divide setting gives 256>>N pulses per 256 cycles
    for (int k = 0; k < 8; k++) begin
      sfrWrite(REG_A, 8'(k));
      cycles(140);
      n = 0;
      repeat (256) begin @(negedge clk); if (clkEn) n++; end
      check($sformatf("R10 pulse count div %0d", k), n, 256 >> k);
    end

    // R11: a change waits for the prescaler wrap
    sfrWrite(REG_A, 8'h07);
    cycles(140);
    do @(negedge clk); while (!clkEn);
    repeat (20) @(negedge clk);
    sfrWrite(REG_A, 8'h00);
    n = 0;
    repeat (50) begin @(negedge clk); if (clkEn) n++; end
    check("R11 old spacing until wrap", n, 0);
    cycles(130);
    n = 0;
    repeat (10) begin @(negedge clk); if (clkEn) n++; end
    check("R11 new spacing after wrap", n, 10);

    // R6 wrap and R5 clear
    cycles(2100);
    sfrWrite(REG_A, 8'h10);
    @(negedge clk);
    check("R5 tick cleared", int'(tickCount), 0);
    cycles(40);
    sfrWrite(REG_A, 8'h00);
    cycles(100);
    @(negedge clk);
    check("R5 zero write keeps count", int'(tickCount), 1);

    // R7: hold freezes outputs
    gpioOutReq = 4'hA;
    sfrWrite(REG_A, 8'h08);
    gpioOutReq = 4'h5;
    @(negedge clk);
    check("R7 held value", int'(gpioOut), 4'hA);
    sfrWrite(REG_A, 8'h00);
    @(negedge clk);
    check("R7 follows after release", int'(gpioOut), 4'h5);

    // R8: edge while running without hold does nothing
    gpioIn = 4'hE;
    n = 0;
    repeat (8) begin @(negedge clk); if (wakeReset) n++; end
    check("R8 no wake while running", n, 0);
    cycles(1); gpioIn = 4'hF;
    cycles(2);

    // R2 / R8: shutdown then wake on a falling edge
    sfrWrite(REG_A, 8'h80);
    @(negedge clk);
    check("R2 shutdown pulse", int'(shutdownReq), 1);
    @(negedge clk);
    check("R2 shutdown pulse single", int'(shutdownReq), 0);
    cycles(5);
    gpioIn = 4'hB;
    n = 0;
    repeat (12) begin @(negedge clk); if (wakeReset) n++; end
    check("R8 wake pulse length", n, WAKE_PULSE);
    cycles(1); gpioIn = 4'hF; cycles(2);

    // R9: deferred edge under hold
    sfrWrite(REG_A, 8'h08);
    gpioIn = 4'h7;
    cycles(4); gpioIn = 4'hF; cycles(4);
    sfrWrite(REG_A, 8'h88);
    n = 0;
    repeat (12) begin @(negedge clk); if (wakeReset) n++; end
    check("R9 deferred edge wakes", n, WAKE_PULSE);

    // R9: clearing hold discards the remembered edge
    sfrWrite(REG_A, 8'h08);
    gpioIn = 4'hD;
    cycles(3); gpioIn = 4'hF;
    sfrWrite(REG_A, 8'h00);
    cycles(2);
    sfrWrite(REG_A, 8'h80);
    n = 0;
    repeat (10) begin @(negedge clk); if (wakeReset) n++; end
    check("R9 discarded edge no wake", n, 0);
    cycles(1); gpioIn = 4'hE;
    n = 0;
    repeat (12) begin @(negedge clk); if (wakeReset) n++; end
    check("R8 wake from shutdown", n, WAKE_PULSE);
    cycles(1); gpioIn = 4'hF;
    cycles(5);
    finishRun();
  end
endmodule